// File: doc/BRIEF.md
# Serial Control-Register Slave with Run-Time Bit Order

This block is a serial-peripheral slave that gives a host read and write access to a small bank of 8-bit control registers. Every frame is 16 bits long: one instruction byte carrying a direction flag and a 7-bit address, then one data byte. The slave samples its serial inputs with the system clock, detects the serial clock edges, and keeps a bit counter that restarts whenever chip select is released. If chip select stays asserted after a frame, the next 16 bits form a new frame.

Register 0 is the port configuration register. Bit 7 selects 4-wire operation, where read data leaves on a dedicated output. When bit 7 is clear, read data leaves on the shared data line (3-wire). Bit 6 selects LSB-first transfer. Bit 5 is a soft reset that restores every other register and then clears itself. A configuration write takes effect as soon as the frame that carries it has finished, so the next frame under the same chip select already uses the new settings. A run of zero bits returns the configuration to MSB-first 3-wire, whatever state the port was left in.

Top module: `spi_rb_top`

## Requirements
- R1: A frame carries 16 bits, sampled on serial clock rising edges while chip select (active low) is asserted. In MSB-first order the instruction byte arrives with the direction flag first (1 = read, 0 = write), then address bits 6 down to 0, then data bits 7 down to 0.
- R2: A write frame to an address below NREGS stores the data byte. After reset, register 0 holds 0x00 and register n (n ≥ 1) holds n·0x11.
- R3: In a read frame, the first data bit is launched on the falling edge that follows the 8th rising edge, and each following bit is launched on the next falling edge, 8 bits in all. The output enable rises on that first falling edge and drops on the falling edge that follows the 16th rising edge.
- R4: When register 0 bit 6 is 1, both bytes travel LSB-first: address bit 0 arrives first, the direction flag arrives 8th, and read data leaves bit 0 first.
- R5: A configuration write applies from the next frame onward, including a frame under the same chip select.
- R6: When register 0 bit 7 is 1, read data leaves on the dedicated output (sdo). When the bit is 0, read data leaves on the shared line (sdio). The enable of the unused pin stays low.
- R7: Writing register 0 with bit 5 set restores every other register to its reset value. Register 0 keeps the written bits, except bit 5, which reads back 0.
- R8: A read from an address at or above NREGS returns 0x00. A write to such an address changes no register.
- R9: Releasing chip select aborts the frame. An incomplete write is discarded, both output enables drop, and the next frame starts at bit 0.
- R10: Within one chip-select period, a run of 1 to 7 zero bits followed by 24 zero bits leaves register 0 at 0x00 (MSB-first, 3-wire). This holds when the run starts at a frame boundary and when it starts inside the data byte of a frame.
- R11: After reset, both output enables are low and every register holds its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Chip select, active low |
| sdio_in | input | 1 | Serial data from the host (shared line, input side) |
| sdio_out | output | 1 | Read data on the shared line |
| sdio_oe | output | 1 | Drive enable for the shared line |
| sdo_out | output | 1 | Read data on the dedicated output |
| sdo_oe | output | 1 | Drive enable for the dedicated output |
| reg_bank_o | output | NREGS*8 | All register contents; register n sits in bits 8n+7..8n |

## Verification
The properties assume that the serial clock and chip select are slow compared with the system clock: each serial clock phase lasts longer than the synchronizer delay plus two cycles. They also assume that chip select changes only while the serial clock is low and that data changes only in the low phase. Under these assumptions every rising and falling edge is seen exactly once, and output-enable changes can be tied to a detected falling edge. The stimulus holds each phase for eight system clocks, changes data and chip select only while the serial clock is low, and waits several phases around every chip-select change.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 7;
    localparam int FRAME_BITS = 2 * BYTE_W;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    // configuration register layout (address 0)
    localparam int CFG_FOUR_WIRE = 7;
    localparam int CFG_LSB_FIRST = 6;
    localparam int CFG_SOFT_RST  = 5;

    typedef struct packed {
        logic              rw;     // 1 = read
        logic [ADDR_W-1:0] addr;
    } instr_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic [BYTE_W-1:0] bit_rev(input logic [BYTE_W-1:0] v);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[i] = v[BYTE_W-1-i];
        return r;
    endfunction

    // next shift-register value for one received bit in the chosen order
    function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] cur,
                                                   input logic b,
                                                   input logic lsb_first);
        return lsb_first ? {b, cur[BYTE_W-1:1]} : {cur[BYTE_W-2:0], b};
    endfunction

    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        return (idx == 0) ? 8'h00 : 8'((idx % 16) * 17);
    endfunction

endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic csn_i,
    input  logic din_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic din
);
    logic [STAGES-1:0] sclk_r, csn_r, din_r;
    logic              sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_r <= '0;
            csn_r  <= '1;
            din_r  <= '0;
            sclk_d <= 1'b0;
        end else begin
            sclk_r <= {sclk_r[STAGES-2:0], sclk_i};
            csn_r  <= {csn_r[STAGES-2:0], csn_i};
            din_r  <= {din_r[STAGES-2:0], din_i};
            sclk_d <= sclk_r[STAGES-1];
        end
    end

    assign sclk_rise = sclk_r[STAGES-1] & ~sclk_d;
    assign sclk_fall = ~sclk_r[STAGES-1] & sclk_d;
    assign cs_act    = ~csn_r[STAGES-1];
    assign din       = din_r[STAGES-1];

endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame
    import spi_rb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sclk_rise,
    input  logic                  sclk_fall,
    input  logic                  cs_act,
    input  logic                  din,
    input  logic                  lsb_first,
    input  logic [BYTE_W-1:0]     rd_data,
    output logic [ADDR_W-1:0]     rd_addr,
    output wr_req_t               wr,
    output logic                  oe,
    output logic                  dout,
    output logic [CNT_W-1:0]      bit_cnt
);
    localparam logic [CNT_W-1:0] LAST_INSTR = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] LAST_BIT   = CNT_W'(FRAME_BITS - 1);

    logic [BYTE_W-1:0] sh, sh_nx, tx, ordered;
    instr_t            instr;
    logic              rd_pend;

    assign sh_nx   = shift_in(sh, din, lsb_first);
    assign ordered = lsb_first ? bit_rev(rd_data) : rd_data;
    assign rd_addr = instr.addr;

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            bit_cnt <= '0;
            sh      <= '0;
            instr   <= '0;
            rd_pend <= 1'b0;
            oe      <= 1'b0;
            dout    <= 1'b0;
            tx      <= '0;
            wr      <= '0;
        end else begin
            wr.en <= 1'b0;
            if (sclk_rise) begin
                sh      <= sh_nx;
                bit_cnt <= bit_cnt + 1'b1;   // wraps: next frame begins
                if (bit_cnt == LAST_INSTR) begin
                    instr   <= instr_t'(sh_nx);
                    rd_pend <= sh_nx[BYTE_W-1];
                end
                if (bit_cnt == LAST_BIT && !instr.rw) begin
                    wr.en   <= 1'b1;
                    wr.addr <= instr.addr;
                    wr.data <= sh_nx;
                end
            end
            if (sclk_fall) begin
                // top counter bit set = data phase (counts 8..15)
                if (rd_pend && bit_cnt[CNT_W-1]) begin
                    if (!oe) begin
                        oe   <= 1'b1;
                        dout <= ordered[BYTE_W-1];
                        tx   <= {ordered[BYTE_W-2:0], 1'b0};
                    end else begin
                        dout <= tx[BYTE_W-1];
                        tx   <= {tx[BYTE_W-2:0], 1'b0};
                    end
                end else if (bit_cnt == '0) begin
                    oe      <= 1'b0;
                    rd_pend <= 1'b0;
                    dout    <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/spi_rb_regs.sv
module spi_rb_regs
    import spi_rb_pkg::*;
#(
    parameter int NREGS = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  wr_req_t                 wr,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [BYTE_W-1:0]       rd_data,
    output logic [BYTE_W-1:0]       cfg,
    output logic [NREGS*BYTE_W-1:0] bank_o
);
    localparam int                IDX_W = $clog2(NREGS);
    localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(NREGS - 1);

    logic [BYTE_W-1:0] mem [NREGS];
    logic              wr_hit, rd_hit;

    assign wr_hit = wr.en && (wr.addr <= LAST);
    assign rd_hit = (rd_addr <= LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) mem[i] <= reg_default(i);
        end else begin
            if (mem[0][CFG_SOFT_RST]) mem[0][CFG_SOFT_RST] <= 1'b0;
            if (wr_hit) begin
                mem[wr.addr[IDX_W-1:0]] <= wr.data;
                if (wr.addr == '0 && wr.data[CFG_SOFT_RST]) begin
                    for (int i = 1; i < NREGS; i++) mem[i] <= reg_default(i);
                end
            end
        end
    end

    assign rd_data = rd_hit ? mem[rd_addr[IDX_W-1:0]] : '0;
    assign cfg     = mem[0];

    for (genvar g = 0; g < NREGS; g++) begin : g_flat
        assign bank_o[g*BYTE_W +: BYTE_W] = mem[g];
    end

endmodule

// File: rtl/spi_rb_top.sv
module spi_rb_top
    import spi_rb_pkg::*;
#(
    parameter int NREGS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    spi_sclk,
    input  logic                    spi_csn,
    input  logic                    sdio_in,
    output logic                    sdio_out,
    output logic                    sdio_oe,
    output logic                    sdo_out,
    output logic                    sdo_oe,
    output logic [NREGS*BYTE_W-1:0] reg_bank_o
);
    logic              sclk_rise, sclk_fall, cs_act, din;
    logic [BYTE_W-1:0] rd_data, cfg;
    logic [ADDR_W-1:0] rd_addr;
    wr_req_t           wr_req;
    logic              oe_int, dout;
    logic [CNT_W-1:0]  bit_cnt;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic              four_wire;

    spi_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .sclk_i(spi_sclk), .csn_i(spi_csn), .din_i(sdio_in),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_act(cs_act), .din(din)
    );

    spi_rb_frame u_frame (
        .clk(clk), .rst(rst),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_act(cs_act), .din(din),
        .lsb_first(cfg[CFG_LSB_FIRST]),
        .rd_data(rd_data), .rd_addr(rd_addr),
        .wr(wr_req), .oe(oe_int), .dout(dout), .bit_cnt(bit_cnt)
    );

    spi_rb_regs #(.NREGS(NREGS)) u_regs (
        .clk(clk), .rst(rst),
        .wr(wr_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .cfg(cfg), .bank_o(reg_bank_o)
    );

    assign wr_en     = wr_req.en;
    assign wr_addr   = wr_req.addr;
    assign four_wire = cfg[CFG_FOUR_WIRE];

    assign sdio_oe  = oe_int & ~four_wire;
    assign sdo_oe   = oe_int & four_wire;
    assign sdio_out = dout & sdio_oe;
    assign sdo_out  = dout & sdo_oe;

endmodule

// File: rtl/spi_rb_chk.sv
module spi_rb_chk
    import spi_rb_pkg::*;
#(
    parameter int NREGS = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    cs_act,
    input logic                    sclk_fall,
    input logic                    oe_int,
    input logic                    sdio_oe,
    input logic                    sdo_oe,
    input logic [NREGS*BYTE_W-1:0] bank,
    input logic                    wr_en,
    input logic [ADDR_W-1:0]       wr_addr,
    input logic [CNT_W-1:0]        bit_cnt
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NREGS - 1);

    function automatic logic others_default(input logic [NREGS*BYTE_W-1:0] b);
        logic ok = 1'b1;
        for (int i = 1; i < NREGS; i++)
            if (b[i*BYTE_W +: BYTE_W] != reg_default(i)) ok = 1'b0;
        return ok;
    endfunction

    p_pin_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(sdio_oe && sdo_oe));

    p_idle_release_r9: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> (!oe_int && bit_cnt == '0));

    p_launch_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_int) |-> $past(sclk_fall));

    p_srst_selfclear_r7: assert property (@(posedge clk) disable iff (rst)
        bank[CFG_SOFT_RST] |=> !bank[CFG_SOFT_RST]);

    p_srst_defaults_r7: assert property (@(posedge clk) disable iff (rst)
        bank[CFG_SOFT_RST] |-> others_default(bank));

    p_unimpl_write_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr > LAST) |=> $stable(bank));

endmodule

bind spi_rb_top spi_rb_chk #(.NREGS(NREGS)) u_chk (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sclk_fall(sclk_fall),
    .oe_int(oe_int), .sdio_oe(sdio_oe), .sdo_oe(sdo_oe),
    .bank(reg_bank_o), .wr_en(wr_en), .wr_addr(wr_addr), .bit_cnt(bit_cnt)
);

// File: tb/sim_spi_rb_top.sv
module sim_spi_rb_top;
    localparam int NREGS = 8;
    localparam int HP    = 8;   // system clocks per serial clock phase

    logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, csn = 1'b1, sdio = 1'b0;
    logic sdio_out, sdio_oe, sdo_out, sdo_oe;
    logic [NREGS*8-1:0] bank;

    spi_rb_top #(.NREGS(NREGS)) u0 (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_csn(csn), .sdio_in(sdio),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
        .reg_bank_o(bank)
    );

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        logic [7:0] val;
        logic       lsb;
        logic       four;
        string      req;
    } exp_t;

    exp_t       exp_q[$];
    int         checks = 0, errors = 0;
    logic [7:0] model[NREGS];
    bit         done = 0;

    function automatic logic [7:0] dflt(int i);
        return (i == 0) ? 8'h00 : 8'(i * 17);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic chk_all(input string req);
        for (int i = 0; i < NREGS; i++) chk(req, bank[i*8 +: 8], model[i]);
    endtask

    task automatic send_bit(input logic b);
        sdio = b;
        repeat (HP) @(negedge clk);
        sclk = 1'b1;
        repeat (HP) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic lsb);
        for (int i = 0; i < 8; i++) send_bit(lsb ? b[i] : b[7-i]);
    endtask

    task automatic cs_on;
        @(negedge clk) csn = 1'b0;
        repeat (HP) @(negedge clk);
    endtask

    task automatic cs_off;
        repeat (HP) @(negedge clk);
        csn = 1'b1;
        repeat (2*HP) @(negedge clk);
    endtask

    task automatic xact(input logic rw, input logic [6:0] a, input logic [7:0] d, input logic lsb);
        send_byte({rw, a}, lsb);
        send_byte(d, lsb);
    endtask

    task automatic wr_reg(input logic [6:0] a, input logic [7:0] d, input logic lsb);
        cs_on; xact(1'b0, a, d, lsb); cs_off;
    endtask

    task automatic rd_reg(input logic [6:0] a, input logic [7:0] v, input logic lsb,
                          input logic four, input string req);
        exp_t e;
        e.val = v; e.lsb = lsb; e.four = four; e.req = req;
        exp_q.push_back(e);
        cs_on; xact(1'b1, a, 8'h00, lsb); cs_off;
    endtask

    // monitor: collects driven bits at each host sampling edge and scores them
    initial begin
        logic [7:0] acc;
        logic       on_sdo, on_sdio;
        int         nb;
        exp_t       e;
        nb = 0; on_sdo = 0; on_sdio = 0; acc = '0;
        forever begin
            @(posedge sclk or posedge csn);
            if (csn) begin
                nb = 0; on_sdo = 0; on_sdio = 0;
            end else if (sdio_oe || sdo_oe) begin
                acc[7-nb] = sdo_oe ? sdo_out : sdio_out;
                on_sdo  = on_sdo | sdo_oe;
                on_sdio = on_sdio | sdio_oe;
                nb++;
                if (nb == 8) begin
                    if (exp_q.size() == 0) begin
                        chk("R3 unexpected read", 32'(acc), 32'hFFFF);
                    end else begin
                        e = exp_q.pop_front();
                        chk(e.req, 32'(e.lsb ? {acc[0],acc[1],acc[2],acc[3],acc[4],acc[5],acc[6],acc[7]} : acc), 32'(e.val));
                        chk("R6 pin", {30'd0, on_sdo, on_sdio}, e.four ? 32'd2 : 32'd1);
                    end
                    nb = 0; on_sdo = 0; on_sdio = 0;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREGS; i++) model[i] = dflt(i);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R11 reset state
        chk_all("R11");
        chk("R11 oe", {30'd0, sdio_oe, sdo_oe}, 32'd0);

        // R1/R3 basic MSB-first read, R2 write
        rd_reg(7'd3, 8'h33, 0, 0, "R1 read");
        wr_reg(7'd2, 8'hA5, 0);
        model[2] = 8'hA5;
        chk_all("R2");
        rd_reg(7'd2, 8'hA5, 0, 0, "R3 read");

        // R8 unimplemented address
        wr_reg(7'h40, 8'h5A, 0);
        chk_all("R8 write ignored");
        rd_reg(7'h40, 8'h00, 0, 0, "R8 read zero");

        // R5 bit order switches for the next frame under the same chip select
        begin
            exp_t e;
            e.val = 8'hA5; e.lsb = 1; e.four = 0; e.req = "R5 same-cs switch";
            exp_q.push_back(e);
        end
        cs_on;
        xact(1'b0, 7'd0, 8'h40, 0);
        xact(1'b1, 7'd2, 8'h00, 1);
        cs_off;
        model[0] = 8'h40;
        chk_all("R5");

        // R4 LSB-first write and read
        wr_reg(7'd5, 8'h3C, 1);
        model[5] = 8'h3C;
        chk_all("R4");
        rd_reg(7'd5, 8'h3C, 1, 0, "R4 read");

        // R6 four-wire output
        wr_reg(7'd0, 8'hC0, 1);
        model[0] = 8'hC0;
        rd_reg(7'd5, 8'h3C, 1, 1, "R6 read");

        // R7 soft reset
        wr_reg(7'd0, 8'hE0, 1);
        for (int i = 1; i < NREGS; i++) model[i] = dflt(i);
        model[0] = 8'hC0;
        chk_all("R7");
        rd_reg(7'd0, 8'hC0, 1, 1, "R7 read cfg");

        // R10 recovery from frame start
        cs_on;
        repeat (3) send_bit(1'b0);
        repeat (24) send_bit(1'b0);
        cs_off;
        model[0] = 8'h00;
        chk_all("R10 aligned");
        rd_reg(7'd3, 8'h33, 0, 0, "R10 msb read");

        // R10 recovery from inside a data byte
        wr_reg(7'd0, 8'h40, 0);
        cs_on;
        send_byte({1'b0, 7'h7F}, 1);
        send_bit(1'b1);
        repeat (7) send_bit(1'b0);
        repeat (24) send_bit(1'b0);
        cs_off;
        model[0] = 8'h00;
        chk_all("R10 misaligned");

        // R9 abort of a write
        cs_on;
        send_byte({1'b0, 7'd3}, 0);
        repeat (4) send_bit(1'b1);
        cs_off;
        chk_all("R9 write aborted");
        chk("R9 oe", {30'd0, sdio_oe, sdo_oe}, 32'd0);

        // R9 abort during read data
        cs_on;
        send_byte({1'b1, 7'd2}, 0);
        repeat (3) send_bit(1'b0);
        repeat (4) @(negedge clk);
        chk("R3 enable during read", {31'd0, sdio_oe}, 32'd1);
        cs_off;
        chk("R9 release", {30'd0, sdio_oe, sdo_oe}, 32'd0);
        rd_reg(7'd3, 8'h33, 0, 0, "R9 realigned");

        chk("R3 all reads seen", 32'(exp_q.size()), 32'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule